// File: doc/BRIEF.md
# ATA Device Interrupt Request Logic

This block drives the host interrupt line of a parallel ATA style device. It holds one pending-interrupt flag, sets it at the points of a PIO command where the host has to be told that data or status is ready, and clears it on the events that acknowledge an interrupt. The flag reaches the line only while the device is selected and the interrupt-disable bit of the device control register is 0. Otherwise the pad driver is switched off, so the line floats. The pad is modelled as a value output and an output enable.

The register decoder and the command engine sit outside the block and deliver decoded single-cycle strobes. A command start carries a 2-bit kind and a total sector count. A sector-done strobe marks each transferred sector, and a command-end strobe marks completion. The block counts sectors to find block boundaries. A block is one sector, or the count last loaded by the Set Multiple command. Data-in commands interrupt at the start of every block. Write-type data-out commands skip the interrupt ahead of the first block and interrupt at completion instead.

Top module: `ata_irq_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the pending flag, the stored disable bit, the latched command kind and the transfer state are cleared, and the block size becomes 1. `irq_val` and `irq_oe` read 0 after that edge.
- R2: The outputs are registered. After each edge, `irq_oe` is 1 exactly when `dev_sel` was 1 and the disable bit (as updated by that edge) is 0. `irq_val` is 1 exactly when `irq_oe` is 1 and the flag (as updated by that edge) is 1. The disable bit is loaded from `ctl_irq_mask` on every `ctl_wr`.
- R3: When the disable bit is 1 or `dev_sel` is 0, `irq_oe` and `irq_val` are both 0 (line undriven). The pending flag is kept, and it shows again once the line is enabled.
- R4: The pending flag is cleared by any of four events: `rst`; `ctl_wr` with `ctl_soft_rst`=1; `cmd_wr`; or `stat_rd` with `stat_rd_alt`=0.
- R5: A status read with `stat_rd_alt`=1 (the alternate status register) leaves the pending flag unchanged.
- R6: When a set event and a clear event occur in the same cycle, the flag ends up set.
- R7: `mult_wr` loads the block size from `mult_val`, and a value of 0 loads 1. `cmd_start` latches the block size that is in force before that edge. Kind codes on `cmd_kind` are: 2'b00 none, 2'b01 data-in, 2'b10 write-type data-out, 2'b11 no-data.
- R8: For a data-in command with count N≥1, the flag is set in the `cmd_start` cycle. It is also set on each `sector_done` that closes a block while sectors remain. Closing the last block does not set it, and neither does `cmd_end`.
- R9: For a write-type command, `cmd_start` does not set the flag. A `sector_done` that closes a non-last block sets it, and `cmd_end` sets it.
- R10: For a no-data command, only `cmd_end` sets the flag. `cmd_end` returns the latched kind to none, so a further `cmd_end` sets nothing.
- R11: `sector_done` outside an active transfer is ignored. A data command started with count 0 starts no transfer and raises no start interrupt.
- R12: A soft reset (`ctl_wr` with `ctl_soft_rst`=1) aborts the transfer and forgets the command kind, so a later `cmd_end` sets nothing. Precedence is soft reset, then `cmd_start`, then `cmd_end`, then `sector_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| dev_sel | input | 1 | This device is the one currently selected |
| ctl_wr | input | 1 | Device control register write strobe |
| ctl_irq_mask | input | 1 | Interrupt-disable bit of the control write |
| ctl_soft_rst | input | 1 | Soft-reset bit of the control write |
| cmd_wr | input | 1 | Host write to the command register |
| stat_rd | input | 1 | Host read of a status register |
| stat_rd_alt | input | 1 | The read targets the alternate status register |
| mult_wr | input | 1 | Set Multiple accepted: load block size |
| mult_val | input | MULT_W | Sectors per block for Set Multiple |
| cmd_start | input | 1 | Command start strobe |
| cmd_kind | input | 2 | Command kind code |
| cmd_count | input | CNT_W | Total sectors of the command |
| sector_done | input | 1 | One sector has been transferred |
| cmd_end | input | 1 | Command completed |
| irq_val | output | 1 | Value driven on the interrupt line |
| irq_oe | output | 1 | Pad enable; 0 leaves the line undriven |

## Verification
The bench aims at the first-block rule of write-type commands. A design that does not special-case them would raise an interrupt at `cmd_start` and so break R9. The bench also checks that the last block of a data-in command stays silent, that short final blocks are handled when the count is not a multiple of the block size, and that a block size of 0 falls back to 1. A wrong counter there would interrupt one sector early or late. Same-cycle set and clear is driven deliberately, because a clear-wins design would lose an interrupt. Alternate status reads and masked periods are driven while the flag is pending, because a design that clears on those, or that forgets the flag while the line floats, would never show the interrupt again.

// File: rtl/ata_irq_pkg.sv
package ata_irq_pkg;
  typedef enum logic [1:0] {
    CMD_NONE = 2'b00,
    CMD_RD   = 2'b01,
    CMD_WR   = 2'b10,
    CMD_ND   = 2'b11
  } cmd_kind_e;
endpackage

// File: rtl/ata_irq_blkseq.sv
// Sector/block sequencer: decides when a command asks for an interrupt.
module ata_irq_blkseq
  import ata_irq_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int MULT_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              abort,
  input  logic              cmd_start,
  input  logic [1:0]        cmd_kind,
  input  logic [CNT_W-1:0]  cmd_count,
  input  logic              mult_wr,
  input  logic [MULT_W-1:0] mult_val,
  input  logic              sector_done,
  input  logic              cmd_end,
  output logic              set_evt
);
  localparam logic [MULT_W-1:0] BLK_ONE  = MULT_W'(1);
  localparam logic [MULT_W-1:0] BLK_ZERO = '0;
  localparam logic [CNT_W-1:0]  CNT_ZERO = '0;

  cmd_kind_e         kind_q;
  logic              active_q;
  logic [CNT_W-1:0]  remain_q;
  logic [MULT_W-1:0] inblk_q;
  logic [MULT_W-1:0] cur_q;
  logic [MULT_W-1:0] blksz_q;

  logic [CNT_W-1:0]  remain_dec;
  logic [MULT_W-1:0] inblk_inc;
  logic              blk_close;
  logic              last_sec;
  logic              data_kind;

  assign remain_dec = remain_q - CNT_W'(1);
  assign inblk_inc  = inblk_q + BLK_ONE;
  assign last_sec   = (remain_dec == CNT_ZERO);
  assign blk_close  = (inblk_inc == cur_q) || last_sec;
  assign data_kind  = (cmd_kind == CMD_RD) || (cmd_kind == CMD_WR);

  // Block size register (Set Multiple); 0 means one sector.
  always_ff @(posedge clk) begin
    if (rst)
      blksz_q <= BLK_ONE;
    else if (mult_wr)
      blksz_q <= (mult_val == BLK_ZERO) ? BLK_ONE : mult_val;
  end

  always_ff @(posedge clk) begin
    if (rst || abort) begin
      kind_q   <= CMD_NONE;
      active_q <= 1'b0;
      remain_q <= CNT_ZERO;
      inblk_q  <= BLK_ZERO;
      cur_q    <= BLK_ONE;
    end else if (cmd_start) begin
      kind_q   <= cmd_kind_e'(cmd_kind);
      active_q <= data_kind && (cmd_count != CNT_ZERO);
      remain_q <= cmd_count;
      inblk_q  <= BLK_ZERO;
      cur_q    <= blksz_q;
    end else if (cmd_end) begin
      kind_q   <= CMD_NONE;
      active_q <= 1'b0;
    end else if (sector_done && active_q) begin
      remain_q <= remain_dec;
      inblk_q  <= blk_close ? BLK_ZERO : inblk_inc;
      if (last_sec)
        active_q <= 1'b0;
    end
  end

  always_comb begin
    set_evt = 1'b0;
    if (rst || abort)
      set_evt = 1'b0;
    else if (cmd_start)
      set_evt = (cmd_kind == CMD_RD) && (cmd_count != CNT_ZERO);
    else if (cmd_end)
      set_evt = (kind_q == CMD_WR) || (kind_q == CMD_ND);
    else if (sector_done && active_q)
      set_evt = blk_close && !last_sec;
  end
endmodule

// File: rtl/ata_irq_pend.sv
// Pending-interrupt flag; a set beats a clear in the same cycle.
module ata_irq_pend (
  input  logic clk,
  input  logic rst,
  input  logic set_evt,
  input  logic clr_evt,
  output logic pend_q,
  output logic pend_d
);
  always_comb begin
    if (rst)          pend_d = 1'b0;
    else if (set_evt) pend_d = 1'b1;
    else if (clr_evt) pend_d = 1'b0;
    else              pend_d = pend_q;
  end

  always_ff @(posedge clk) begin
    if (rst) pend_q <= 1'b0;
    else     pend_q <= pend_d;
  end
endmodule

// File: rtl/ata_irq_drive.sv
// Disable-bit register and registered pad value / enable.
module ata_irq_drive (
  input  logic clk,
  input  logic rst,
  input  logic ctl_wr,
  input  logic ctl_irq_mask,
  input  logic dev_sel,
  input  logic pend_d,
  output logic irq_val,
  output logic irq_oe
);
  logic mask_q;
  logic mask_d;
  logic en_d;

  assign mask_d = ctl_wr ? ctl_irq_mask : mask_q;
  assign en_d   = dev_sel && !mask_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q  <= 1'b0;
      irq_oe  <= 1'b0;
      irq_val <= 1'b0;
    end else begin
      mask_q  <= mask_d;
      irq_oe  <= en_d;
      irq_val <= en_d && pend_d;
    end
  end
endmodule

// File: rtl/ata_irq_ctrl.sv
module ata_irq_ctrl #(
  parameter int CNT_W  = 16,
  parameter int MULT_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dev_sel,
  input  logic              ctl_wr,
  input  logic              ctl_irq_mask,
  input  logic              ctl_soft_rst,
  input  logic              cmd_wr,
  input  logic              stat_rd,
  input  logic              stat_rd_alt,
  input  logic              mult_wr,
  input  logic [MULT_W-1:0] mult_val,
  input  logic              cmd_start,
  input  logic [1:0]        cmd_kind,
  input  logic [CNT_W-1:0]  cmd_count,
  input  logic              sector_done,
  input  logic              cmd_end,
  output logic              irq_val,
  output logic              irq_oe
);
  logic soft_rst;
  logic clr_evt;
  logic set_evt;
  logic pend_q;
  logic pend_d;

  assign soft_rst = ctl_wr && ctl_soft_rst;
  // Alternate status reads do not acknowledge the interrupt.
  assign clr_evt  = soft_rst || cmd_wr || (stat_rd && !stat_rd_alt);

  ata_irq_blkseq #(.CNT_W(CNT_W), .MULT_W(MULT_W)) u_seq (
    .clk         (clk),
    .rst         (rst),
    .abort       (soft_rst),
    .cmd_start   (cmd_start),
    .cmd_kind    (cmd_kind),
    .cmd_count   (cmd_count),
    .mult_wr     (mult_wr),
    .mult_val    (mult_val),
    .sector_done (sector_done),
    .cmd_end     (cmd_end),
    .set_evt     (set_evt)
  );

  ata_irq_pend u_pend (
    .clk     (clk),
    .rst     (rst),
    .set_evt (set_evt),
    .clr_evt (clr_evt),
    .pend_q  (pend_q),
    .pend_d  (pend_d)
  );

  ata_irq_drive u_drv (
    .clk          (clk),
    .rst          (rst),
    .ctl_wr       (ctl_wr),
    .ctl_irq_mask (ctl_irq_mask),
    .dev_sel      (dev_sel),
    .pend_d       (pend_d),
    .irq_val      (irq_val),
    .irq_oe       (irq_oe)
  );
endmodule

// File: rtl/ata_irq_chk.sv
module ata_irq_chk (
  input logic clk,
  input logic rst,
  input logic dev_sel,
  input logic ctl_wr,
  input logic ctl_irq_mask,
  input logic ctl_soft_rst,
  input logic cmd_wr,
  input logic stat_rd,
  input logic stat_rd_alt,
  input logic set_evt,
  input logic pend_q,
  input logic irq_val,
  input logic irq_oe
);
  assert_val_needs_oe_R3: assert property (@(posedge clk) disable iff (rst)
    irq_val |-> irq_oe);

  assert_desel_hiz_R3: assert property (@(posedge clk) disable iff (rst)
    !dev_sel |=> !irq_oe);

  assert_mask_hiz_R2: assert property (@(posedge clk) disable iff (rst)
    (ctl_wr && ctl_irq_mask) |=> !irq_oe);

  assert_unmask_shows_R2: assert property (@(posedge clk) disable iff (rst)
    (dev_sel && ctl_wr && !ctl_irq_mask) |=> (irq_oe && (irq_val == pend_q)));

  assert_set_wins_R6: assert property (@(posedge clk) disable iff (rst)
    set_evt |=> pend_q);

  assert_cmdwr_clr_R4: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr && !set_evt) |=> !pend_q);

  assert_alt_keep_R5: assert property (@(posedge clk) disable iff (rst)
    (pend_q && stat_rd && stat_rd_alt && !cmd_wr && !(ctl_wr && ctl_soft_rst))
      |=> pend_q);
endmodule

bind ata_irq_ctrl ata_irq_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .dev_sel      (dev_sel),
  .ctl_wr       (ctl_wr),
  .ctl_irq_mask (ctl_irq_mask),
  .ctl_soft_rst (ctl_soft_rst),
  .cmd_wr       (cmd_wr),
  .stat_rd      (stat_rd),
  .stat_rd_alt  (stat_rd_alt),
  .set_evt      (set_evt),
  .pend_q       (pend_q),
  .irq_val      (irq_val),
  .irq_oe       (irq_oe)
);

// File: tb/ata_irq_ctrl_tb.sv
module ata_irq_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W  = 16;
  localparam int MULT_W = 8;
  localparam logic [1:0] K_NONE = 2'b00, K_RD = 2'b01, K_WR = 2'b10, K_ND = 2'b11;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic dev_sel = 1'b0, ctl_wr = 1'b0, ctl_irq_mask = 1'b0, ctl_soft_rst = 1'b0;
  logic cmd_wr = 1'b0, stat_rd = 1'b0, stat_rd_alt = 1'b0, mult_wr = 1'b0;
  logic [MULT_W-1:0] mult_val = '0;
  logic cmd_start = 1'b0;
  logic [1:0] cmd_kind = K_NONE;
  logic [CNT_W-1:0] cmd_count = '0;
  logic sector_done = 1'b0, cmd_end = 1'b0;
  logic irq_val, irq_oe;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  // reference state
  bit m_pend, m_mask, m_active;
  logic [1:0] m_kind;
  int m_remain, m_inblk, m_cur, m_blksz;
  bit exp_val, exp_oe;

  always #(CLK_PERIOD/2) clk = ~clk;

  ata_irq_ctrl #(.CNT_W(CNT_W), .MULT_W(MULT_W)) u_dut (
    .clk(clk), .rst(rst), .dev_sel(dev_sel), .ctl_wr(ctl_wr),
    .ctl_irq_mask(ctl_irq_mask), .ctl_soft_rst(ctl_soft_rst), .cmd_wr(cmd_wr),
    .stat_rd(stat_rd), .stat_rd_alt(stat_rd_alt), .mult_wr(mult_wr),
    .mult_val(mult_val), .cmd_start(cmd_start), .cmd_kind(cmd_kind),
    .cmd_count(cmd_count), .sector_done(sector_done), .cmd_end(cmd_end),
    .irq_val(irq_val), .irq_oe(irq_oe)
  );

  task automatic check(input string tag, input bit v, input bit o);
    total++;
    if (irq_val !== v || irq_oe !== o) begin
      bad++;
      $display("FAIL %s: val=%0b oe=%0b expected val=%0b oe=%0b at %0t",
               tag, irq_val, irq_oe, v, o, $time);
    end
  endtask

  // Expected next state from the requirements, for the inputs now applied.
  task automatic model_step();
    bit srst, setv, clr, last, close;
    if (rst) begin
      m_pend = 0; m_mask = 0; m_active = 0; m_kind = K_NONE;
      m_remain = 0; m_inblk = 0; m_cur = 1; m_blksz = 1;
      exp_val = 0; exp_oe = 0;
      return;
    end
    srst = ctl_wr && ctl_soft_rst;
    setv = 0;
    if (srst) begin
      m_active = 0; m_kind = K_NONE; m_remain = 0; m_inblk = 0; m_cur = 1;
    end else if (cmd_start) begin
      setv = (cmd_kind == K_RD) && (cmd_count != 0);
      m_kind = cmd_kind;
      m_active = (cmd_kind == K_RD || cmd_kind == K_WR) && (cmd_count != 0);
      m_remain = int'(cmd_count); m_inblk = 0; m_cur = m_blksz;
    end else if (cmd_end) begin
      setv = (m_kind == K_WR) || (m_kind == K_ND);
      m_kind = K_NONE; m_active = 0;
    end else if (sector_done && m_active) begin
      last = (m_remain == 1);
      close = last || (m_inblk + 1 == m_cur);
      setv = close && !last;
      m_remain--;
      m_inblk = close ? 0 : m_inblk + 1;
      if (last) m_active = 0;
    end
    if (mult_wr) m_blksz = (mult_val == 0) ? 1 : int'(mult_val);
    clr = srst || cmd_wr || (stat_rd && !stat_rd_alt);
    if (setv) m_pend = 1; else if (clr) m_pend = 0;
    if (ctl_wr) m_mask = ctl_irq_mask;
    exp_oe  = dev_sel && !m_mask;
    exp_val = exp_oe && m_pend;
  endtask

  task automatic clear_strobes();
    ctl_wr = 0; ctl_irq_mask = 0; ctl_soft_rst = 0; cmd_wr = 0; stat_rd = 0;
    stat_rd_alt = 0; mult_wr = 0; cmd_start = 0; sector_done = 0; cmd_end = 0;
  endtask

  task automatic tick(input string tag);
    model_step();
    @(posedge clk);
    #1;
    check(tag, exp_val, exp_oe);
    clear_strobes();
  endtask

  task automatic start_cmd(input logic [1:0] k, input int n);
    cmd_start = 1; cmd_kind = k; cmd_count = CNT_W'(n);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    rst = 1; dev_sel = 1;
    tick("R1"); check("R1", 0, 0);
    tick("R1");
    rst = 0;
    tick("R1"); check("R1", 0, 1);

    // R8: data-in, 3 sectors, block of 1
    start_cmd(K_RD, 3); tick("R8"); check("R8", 1, 1);
    stat_rd = 1; tick("R4"); check("R4", 0, 1);
    sector_done = 1; tick("R8"); check("R8", 1, 1);
    stat_rd = 1; tick("R4");
    sector_done = 1; tick("R8"); check("R8", 1, 1);
    stat_rd = 1; tick("R4");
    sector_done = 1; tick("R8"); check("R8", 0, 1);
    cmd_end = 1; tick("R8"); check("R8", 0, 1);

    // R9 / R7: write-type, 5 sectors, blocks of 2 (last block short)
    mult_wr = 1; mult_val = 2; tick("R7");
    start_cmd(K_WR, 5); tick("R9"); check("R9", 0, 1);
    sector_done = 1; tick("R9"); check("R9", 0, 1);
    sector_done = 1; tick("R9"); check("R9", 1, 1);
    cmd_wr = 1; tick("R4"); check("R4", 0, 1);
    sector_done = 1; tick("R9");
    sector_done = 1; tick("R9"); check("R9", 1, 1);
    stat_rd = 1; tick("R4");
    sector_done = 1; tick("R9"); check("R9", 0, 1);
    cmd_end = 1; tick("R9"); check("R9", 1, 1);

    // R5: alternate status read keeps the flag
    stat_rd = 1; stat_rd_alt = 1; tick("R5"); check("R5", 1, 1);

    // R3: masked or deselected floats, flag retained
    ctl_wr = 1; ctl_irq_mask = 1; tick("R3"); check("R3", 0, 0);
    ctl_wr = 1; ctl_irq_mask = 0; tick("R3"); check("R3", 1, 1);
    dev_sel = 0; tick("R3"); check("R3", 0, 0);
    dev_sel = 1; tick("R3"); check("R3", 1, 1);

    // R4: soft reset clears
    ctl_wr = 1; ctl_soft_rst = 1; tick("R4"); check("R4", 0, 1);

    // R10 / R6: no-data; completion with simultaneous clears
    start_cmd(K_ND, 0); tick("R10"); check("R10", 0, 1);
    cmd_end = 1; cmd_wr = 1; stat_rd = 1; tick("R6"); check("R6", 1, 1);
    stat_rd = 1; tick("R4");
    cmd_end = 1; tick("R10"); check("R10", 0, 1);

    // R11: idle sector_done, zero-count data-in
    sector_done = 1; tick("R11"); check("R11", 0, 1);
    start_cmd(K_RD, 0); tick("R11"); check("R11", 0, 1);
    sector_done = 1; tick("R11"); check("R11", 0, 1);

    // R7: block size 0 means 1
    mult_wr = 1; mult_val = 0; tick("R7");
    start_cmd(K_WR, 2); tick("R7");
    sector_done = 1; tick("R7"); check("R7", 1, 1);
    stat_rd = 1; tick("R4");

    // R12: soft reset aborts a write command
    start_cmd(K_WR, 4); tick("R12");
    ctl_wr = 1; ctl_soft_rst = 1; tick("R12");
    sector_done = 1; tick("R12"); check("R12", 0, 1);
    cmd_end = 1; tick("R12"); check("R12", 0, 1);

    // Random phase against the reference (R2)
    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < 4000; i++) begin
      dev_sel = ($urandom % 10) != 0;
      if ($urandom % 20 == 0) begin
        ctl_wr = 1; ctl_irq_mask = ($urandom % 4) == 0; ctl_soft_rst = ($urandom % 5) == 0;
      end
      cmd_wr  = ($urandom % 30) == 0;
      stat_rd = ($urandom % 8) == 0; stat_rd_alt = $urandom % 2;
      if ($urandom % 30 == 0) begin mult_wr = 1; mult_val = MULT_W'($urandom % 5); end
      if ($urandom % 20 == 0) start_cmd(2'($urandom % 4), int'($urandom % 7));
      sector_done = ($urandom % 3) == 0;
      cmd_end = ($urandom % 25) == 0;
      tick("R2");
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule